// File: doc/BRIEF.md
# Flash Controller Interrupt and FIFO Status Unit

This block holds the register-side status logic of a serial flash controller. Eight event sources from the transfer sequencer and the data FIFOs are captured in a sticky raw status register. A mask register turns that raw view into a masked view and a single interrupt line. Software clears captured events by writing ones to a clear register. The same register port also reports the fill levels and the full/empty flags of the transmit and receive FIFOs, and holds the FIFO threshold settings that the FIFO logic consumes.

A recovery register starts a soft reset of the controller state machine and FIFOs. Once started, the reset holds the `recover_o` output high for a fixed number of cycles. Bit 0 of the recovery register reads 1 for as long as the reset runs, and then clears itself. The mask and threshold settings are unaffected by this reset. The FIFO storage and the serial engine sit outside this block.

Register map (byte addresses): 0x00 mask, 0x04 clear, 0x08 raw status, 0x0C masked status, 0x10 FIFO status, 0x14 thresholds, 0x18 recovery. Event bit positions, used in every event register: 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 serial error, 7 DMA done.

Top module: `flash_irq_stat`

## Requirements
- R1: After reset the mask register reads 0xFF, and the raw status, masked status, thresholds and recovery registers read 0. `irq_o` and `recover_o` are low.
- R2: A high `event_i[n]` sets raw status bit n (address 0x08) on the next clock edge, whatever the mask holds. The bit then stays set until it is cleared.
- R3: Writing address 0x04 clears each raw status bit whose write-data bit is 1. Write-data bits that are 0 leave the matching raw bits unchanged. Address 0x04 reads as 0.
- R4: If an event and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R5: Address 0x0C reads raw AND NOT mask in bits 7:0. `irq_o` is high exactly when any of those bits is 1, so a mask of 0xFF keeps `irq_o` low.
- R6: The mask register at 0x00 is read/write in bits 7:0. A 1 in a mask bit disables that interrupt.
- R7: Address 0x10 reads the FIFO status. Bit 0 is transmit full (level equals FIFO_DEPTH). Bit 1 is transmit empty (level 0). Bit 2 is receive empty. Bit 3 is receive full. Bits 12:8 hold the transmit level and bits 20:16 hold the receive level. All other bits read 0.
- R8: Address 0x14 holds a 5-bit transmit threshold in bits 4:0 and a 5-bit receive threshold in bits 12:8. Both thresholds drive outputs, and all other bits read 0.
- R9: Writing 1 to bit 0 of address 0x18 drives `recover_o` high, and bit 0 of 0x18 reads 1, for exactly RCV_CYCLES cycles. After that both return to 0. Writing 0 to that bit starts nothing. The reset leaves the mask, the thresholds and the raw status unchanged.
- R10: Any address outside the map reads 0, and writes to the read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| event_i | input | 8 | Event pulses from the sequencer and FIFOs |
| tx_level_i | input | LVW | Transmit FIFO fill level |
| rx_level_i | input | LVW | Receive FIFO fill level |
| irq_o | output | 1 | Interrupt, OR of the masked status |
| tx_thresh_o | output | 5 | Transmit FIFO threshold |
| rx_thresh_o | output | 5 | Receive FIFO threshold |
| recover_o | output | 1 | Soft reset to the state machine and FIFOs |

## Verification
Each register update from a write or an event becomes visible after the single clock edge that follows the stimulus. Read data and `irq_o` are combinational from those registers, and the FIFO status follows the level inputs within the same cycle. The bench therefore drives all inputs on the falling edge and samples one falling edge later, after exactly one rising edge. For the recovery reset it counts falling edges from the write and expects `recover_o` high on the first RCV_CYCLES of them and low on the next one. The sweeps cover every event bit, all 256 mask values and every pair of FIFO levels from 0 to FIFO_DEPTH.

// File: rtl/flash_irq_stat.sv
module flash_irq_stat #(
  parameter int FIFO_DEPTH = 16,
  parameter int RCV_CYCLES = 8,
  localparam int LVW = $clog2(FIFO_DEPTH + 1),
  localparam int RCW = $clog2(RCV_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [7:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic [7:0]     event_i,
  input  logic [LVW-1:0] tx_level_i,
  input  logic [LVW-1:0] rx_level_i,
  output logic           irq_o,
  output logic [4:0]     tx_thresh_o,
  output logic [4:0]     rx_thresh_o,
  output logic           recover_o
);
  localparam logic [7:0] A_MASK = 8'h00;
  localparam logic [7:0] A_CLR  = 8'h04;
  localparam logic [7:0] A_RAW  = 8'h08;
  localparam logic [7:0] A_MSK  = 8'h0C;
  localparam logic [7:0] A_FIFO = 8'h10;
  localparam logic [7:0] A_THR  = 8'h14;
  localparam logic [7:0] A_RCV  = 8'h18;

  logic [7:0]     mask_q, raw_q, clr, masked;
  logic [RCW-1:0] rcv_cnt;
  logic           rcv_busy;
  logic [4:0]     tx_lv5, rx_lv5;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic           unused_wdata;

  assign unused_wdata = &{1'b0, reg_wdata[31:13], reg_wdata[7:5]};

  assign clr    = (reg_wr && reg_addr == A_CLR) ? reg_wdata[7:0] : 8'h00;
  assign masked = raw_q & ~mask_q;
  assign irq_o  = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 8'h00;
    end else begin
      raw_q <= (raw_q & ~clr) | event_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= 8'hFF;
      tx_thresh_o <= 5'd0;
      rx_thresh_o <= 5'd0;
    end else if (reg_wr) begin
      if (reg_addr == A_MASK) mask_q <= reg_wdata[7:0];
      if (reg_addr == A_THR) begin
        tx_thresh_o <= reg_wdata[4:0];
        rx_thresh_o <= reg_wdata[12:8];
      end
    end
  end

  assign rcv_busy  = (rcv_cnt != '0);
  assign recover_o = rcv_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_cnt <= '0;
    end else if (rcv_busy) begin
      rcv_cnt <= rcv_cnt - 1'b1;
    end else if (reg_wr && reg_addr == A_RCV && reg_wdata[0]) begin
      rcv_cnt <= RCW'(RCV_CYCLES);
    end
  end

  assign tx_lv5   = 5'(tx_level_i);
  assign rx_lv5   = 5'(rx_level_i);
  assign tx_full  = (tx_level_i == LVW'(FIFO_DEPTH));
  assign tx_empty = (tx_level_i == '0);
  assign rx_full  = (rx_level_i == LVW'(FIFO_DEPTH));
  assign rx_empty = (rx_level_i == '0);

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = {24'd0, mask_q};
      A_RAW:   reg_rdata = {24'd0, raw_q};
      A_MSK:   reg_rdata = {24'd0, masked};
      A_FIFO:  reg_rdata = {11'd0, rx_lv5, 3'd0, tx_lv5, 4'd0,
                            rx_full, rx_empty, tx_empty, tx_full};
      A_THR:   reg_rdata = {19'd0, rx_thresh_o, 3'd0, tx_thresh_o};
      A_RCV:   reg_rdata = {31'd0, rcv_busy};
      default: reg_rdata = 32'd0;
    endcase
  end

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(event_i)) == $past(event_i)));

  p_no_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_CLR) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CLR && (reg_wdata[7:0] & event_i) != 8'h00)
      |=> ((raw_q & $past(event_i)) == $past(event_i)));

  p_all_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'hFF) |-> !irq_o);

  p_rcv_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recover_o) |-> $past(reg_wr && reg_addr == A_RCV && reg_wdata[0]));

  p_rcv_keeps_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (recover_o && !(reg_wr && reg_addr == A_MASK)) |=> $stable(mask_q));

  p_tx_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_FIFO && tx_level_i == '0) |-> (reg_rdata[1] && !reg_rdata[0]));
endmodule

// File: tb/flash_irq_stat_tb.sv
module flash_irq_stat_tb_top;
  localparam int DEPTH = 16;
  localparam int RCV   = 8;
  localparam int LVW   = $clog2(DEPTH + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [7:0]     reg_addr = 8'h00;
  logic [31:0]    reg_wdata = 32'd0;
  logic [31:0]    reg_rdata;
  logic [7:0]     event_i = 8'h00;
  logic [LVW-1:0] tx_level_i = '0;
  logic [LVW-1:0] rx_level_i = '0;
  logic           irq_o;
  logic [4:0]     tx_thresh_o, rx_thresh_o;
  logic           recover_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_irq_stat #(.FIFO_DEPTH(DEPTH), .RCV_CYCLES(RCV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_i(event_i),
    .tx_level_i(tx_level_i), .rx_level_i(rx_level_i), .irq_o(irq_o),
    .tx_thresh_o(tx_thresh_o), .rx_thresh_o(rx_thresh_o), .recover_o(recover_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] e);
    event_i = e;
    @(negedge clk);
    event_i = 8'h00;
  endtask

  initial begin
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 8'h00, 32'h0000_00FF);
    rd("R1", 8'h08, 32'd0);
    rd("R1", 8'h0C, 32'd0);
    rd("R1", 8'h14, 32'd0);
    rd("R1", 8'h18, 32'd0);
    chk("R1", {30'd0, irq_o, recover_o}, 32'd0);

    // R2/R3/R5 per event bit
    for (int i = 0; i < 8; i++) begin
      m = 8'(1 << i);
      pulse(m);
      rd("R2", 8'h08, {24'd0, m});
      rd("R5", 8'h0C, 32'd0);
      chk("R5", {31'd0, irq_o}, 32'd0);
      repeat (3) @(negedge clk);
      rd("R2", 8'h08, {24'd0, m});
      wr(8'h04, {24'd0, ~m});
      rd("R3", 8'h08, {24'd0, m});
      rd("R3", 8'h04, 32'd0);
      wr(8'h00, {24'd0, ~m});
      rd("R5", 8'h0C, {24'd0, m});
      chk("R5", {31'd0, irq_o}, 32'd1);
      wr(8'h04, {24'd0, m});
      rd("R3", 8'h08, 32'd0);
      chk("R5", {31'd0, irq_o}, 32'd0);
      wr(8'h00, 32'h0000_00FF);
    end

    // R5/R6 sweep over all masks
    pulse(8'hA5);
    for (int k = 0; k < 256; k++) begin
      m = 8'(k);
      wr(8'h00, {24'hABCDEF, m});
      rd("R6", 8'h00, {24'd0, m});
      rd("R5", 8'h0C, {24'd0, 8'hA5 & ~m});
      chk("R5", {31'd0, irq_o}, {31'd0, |(8'hA5 & ~m)});
    end
    wr(8'h04, 32'h0000_00FF);
    rd("R3", 8'h08, 32'd0);

    // R4 event and clear in the same cycle
    for (int i = 0; i < 8; i++) begin
      m = 8'(1 << i);
      event_i = m; reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h0000_00FF;
      @(negedge clk);
      event_i = 8'h00; reg_wr = 1'b0; reg_wdata = 32'd0;
      rd("R4", 8'h08, {24'd0, m});
      wr(8'h04, 32'h0000_00FF);
    end

    // R7 FIFO status sweep
    for (int t = 0; t <= DEPTH; t++) begin
      for (int r = 0; r <= DEPTH; r++) begin
        tx_level_i = LVW'(t);
        rx_level_i = LVW'(r);
        rd("R7", 8'h10, (32'(r) << 16) | (32'(t) << 8) |
                        {28'd0, (r == DEPTH), (r == 0), (t == 0), (t == DEPTH)});
      end
    end
    tx_level_i = '0; rx_level_i = '0;

    // R8 thresholds
    for (int k = 0; k < 32; k++) begin
      wr(8'h14, 32'hFFFF_E0E0 | (32'(31 - k) << 8) | 32'(k));
      rd("R8", 8'h14, (32'(31 - k) << 8) | 32'(k));
      chk("R8", {22'd0, rx_thresh_o, tx_thresh_o}, {22'd0, 5'(31 - k), 5'(k)});
    end

    // R10 unmapped and read-only
    rd("R10", 8'h1C, 32'd0);
    rd("R10", 8'h40, 32'd0);
    rd("R10", 8'hFC, 32'd0);
    wr(8'h08, 32'h0000_00FF);
    rd("R10", 8'h08, 32'd0);

    // R9 recovery
    wr(8'h00, 32'h0000_005A);
    wr(8'h14, 32'h0000_0A05);
    pulse(8'h3C);
    wr(8'h18, 32'h0000_0000);
    chk("R9", {31'd0, recover_o}, 32'd0);
    wr(8'h18, 32'h0000_0001);
    chk("R9", {31'd0, recover_o}, 32'd1);
    rd("R9", 8'h18, 32'd1);
    for (int c = 1; c < RCV; c++) begin
      @(negedge clk);
      chk("R9", {31'd0, recover_o}, 32'd1);
    end
    @(negedge clk);
    chk("R9", {31'd0, recover_o}, 32'd0);
    rd("R9", 8'h18, 32'd0);
    rd("R9", 8'h00, 32'h0000_005A);
    rd("R9", 8'h14, 32'h0000_0A05);
    rd("R9", 8'h08, 32'h0000_003C);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule